// File: doc/BRIEF.md
# Decade Ripple Counter with Partial-Decode Clear

This block is a four-stage asynchronous counter that runs through the decimal digits 0 to 9 and then returns to 0. Only the first stage sees the system clock. It toggles on every rising edge. Each later stage is clocked by the falling edge of the stage before it, so a carry ripples down the chain instead of reaching every stage on the same edge.

The wrap is not a synchronous load. A two-input NAND watches count bits 1 and 3 and nothing else. Within 0..9 those two bits are never high together, so their first joint appearance can only mean the chain has just reached ten (binary 1010). The low NAND output is combined with the external active-low reset and clears every stage asynchronously. The code ten therefore exists only for the instant the clear takes to act. A visibility output, `wrap_pulse`, is high for exactly that interval.

The block is used where a cheap divide-by-ten chain is wanted and the consumer samples the count only after the ripple has settled.

Top module: `ripple_decade_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 regardless of `clk`, and `wrap_pulse` is 0.
- R2: From a settled value k in 0..8, one rising edge of `clk` leaves `count` settled at k+1. The value is unsigned binary, with bit 0 as the least significant bit.
- R3: From a settled value 9, one rising edge of `clk` leaves `count` settled at 0. The clear of the wrap must not clock any stage a second time.
- R4: `count` never settles on a value from 10 to 15. At any sampling point, bits 1 and 3 are never both 1.
- R5: `wrap_pulse` rises exactly once on each rising edge of `clk` that takes the count from 9 to 0, rises at no other time, and is 0 whenever the count is settled.
- R6: Asserting `rst_n` low in the middle of a count returns `count` to 0 without a `wrap_pulse`. After release, counting restarts from 0 and wraps after ten edges.
- R7: The decode looks only at bits 1 and 3. Values 0..9, including 3, 6, 7, 8 and 9, which have bit 1 or bit 3 set alone, pass without a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; the first stage toggles on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of all stages |
| count | output | 4 | Settled decimal digit, unsigned binary, bit 0 least significant |
| wrap_pulse | output | 1 | High only while the partial-decode clear is acting |

## Verification
The hardest situation to observe from the ports is the code ten itself. It lives for zero time in simulation, so it can never be seen at a sampling point. The bench instead counts rising edges of `wrap_pulse` as events. It then compares that tally after every clock against the number of complete decades clocked so far. A hidden clear or a missing one shows up as a wrong tally, and a second toggle caused by the clear shows up as a nonzero settled count. A reset in the middle of a decade checks that the external clear produces no pulse and that the chain then restarts from 0.

// File: rtl/ripdec_pkg.sv
package ripdec_pkg;
    // Number of ripple stages in the chain
    localparam int STAGES   = 4;
    // Counting modulus; the clear fires on this code
    localparam int MODULUS  = 10;
    // Bits watched by the partial decode (both are high only at MODULUS)
    localparam int DEC_HI   = 3;
    localparam int DEC_LO   = 1;

    typedef logic [STAGES-1:0] count_t;
endpackage

// File: rtl/ripdec_tstage.sv
// One toggle stage of the ripple chain.
// FIRST = 1: toggles on rising edge of the trigger (system clock).
// FIRST = 0: toggles on falling edge of the trigger (previous stage
//            output), with the trigger held low while the clear acts so that
//            a stage dropping under the clear does not clock its successor.
module ripdec_tstage #(
    parameter bit FIRST = 1'b0
) (
    input  logic trig,
    input  logic clr_n,
    output logic q
);
    generate
        if (FIRST) begin : g_head
            always_ff @(posedge trig or negedge clr_n) begin
                if (!clr_n) q <= 1'b0;
                else        q <= ~q;
            end
        end else begin : g_tail
            logic gated;
            assign gated = trig & clr_n;
            always_ff @(negedge gated or negedge clr_n) begin
                if (!clr_n) q <= 1'b0;
                else        q <= ~q;
            end
        end
    endgenerate
endmodule

// File: rtl/ripdec_decode.sv
// Partial decode of the terminal code: a NAND of two bits, merged
// (active-low) with the external reset into the common clear.
module ripdec_decode #(
    parameter int W  = 4,
    parameter int HI = 3,
    parameter int LO = 1
) (
    input  logic [W-1:0] cnt,
    input  logic         rst_n,
    output logic         clr_n,
    output logic         hit
);
    logic nand_out;
    assign nand_out = ~(cnt[HI] & cnt[LO]);
    assign hit      = ~nand_out;
    assign clr_n    = rst_n & nand_out;
endmodule

// File: rtl/ripdec_chain.sv
// Chain of toggle stages; stage i > 0 is triggered by stage i-1.
module ripdec_chain #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_first
                ripdec_tstage #(.FIRST(1'b1)) u_st (
                    .trig  (clk),
                    .clr_n (clr_n),
                    .q     (q[i])
                );
            end else begin : g_next
                ripdec_tstage #(.FIRST(1'b0)) u_st (
                    .trig  (q[i-1]),
                    .clr_n (clr_n),
                    .q     (q[i])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/ripple_decade_counter.sv
module ripple_decade_counter
    import ripdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] count,
    output logic              wrap_pulse
);
    count_t q;
    logic   clr_n;
    logic   hit;

    ripdec_chain #(.W(STAGES)) u_chain (
        .clk   (clk),
        .clr_n (clr_n),
        .q     (q)
    );

    ripdec_decode #(.W(STAGES), .HI(DEC_HI), .LO(DEC_LO)) u_dec (
        .cnt   (q),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .hit   (hit)
    );

    assign count      = q;
    assign wrap_pulse = hit;
endmodule

// File: rtl/ripple_decade_counter_chk.sv
module ripple_decade_counter_chk
    import ripdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAGES-1:0] count,
    input logic              wrap_pulse
);
    // Set after the first edge out of reset, so $past never reaches into reset
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2 / R3: settled count advances by one modulo ten per rising edge
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (count == (($past(count) == STAGES'(MODULUS-1)) ?
                             '0 : $past(count) + 1'b1)));

    // R3: after a 9 the next settled value is 0
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(count) == STAGES'(MODULUS-1)) |-> (count == '0));

    // R4: never settles at ten or above
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count < STAGES'(MODULUS));

    // R4: the two decoded bits are never seen high together
    p_no_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(count[DEC_HI] && count[DEC_LO]));

    // R5: clear strobe is never visible at a sampling point
    p_pulse_transient_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_pulse);
endmodule

bind ripple_decade_counter ripple_decade_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .wrap_pulse (wrap_pulse)
);

// File: tb/ripple_decade_counter_tb.sv
`timescale 1ns/1ps
module ripple_decade_counter_tb_top;
    logic       clk;
    logic       rst_n;
    logic [3:0] count;
    logic       wrap_pulse;

    int tests;
    int fails;
    int wraps;

    ripple_decade_counter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .wrap_pulse (wrap_pulse)
    );

    // 200 MHz
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Each zero-width clear is counted as an event
    initial wraps = 0;
    always @(posedge wrap_pulse) wraps = wraps + 1;

    task automatic check(input string tag, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Clocks a run of edges from a settled start value and checks each one
    task automatic run_edges(input int start, input int n, input int wrap_base);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if ((start + i) % 10 == 0)
                check("R3 wrap to zero", int'(count), 0);
            else
                check("R2 increment", int'(count), (start + i) % 10);
            check("R4 bits 1 and 3", int'(count[1] & count[3]), 0);
            check("R5 settled strobe low", int'(wrap_pulse), 0);
            check("R5 wrap tally", wraps, wrap_base + (start + i) / 10);
            if ((start + i) % 10 inside {3, 6, 7, 8, 9})
                check("R7 single decoded bit no clear", wraps,
                      wrap_base + (start + i) / 10);
        end
    endtask

    initial begin
        tests = 0;
        fails = 0;
        rst_n = 1'b1;
        #2;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 count in reset", int'(count), 0);
        check("R1 strobe in reset", int'(wrap_pulse), 0);
        check("R1 no wrap in reset", wraps, 0);

        rst_n = 1'b1;
        run_edges(0, 35, 0);

        // Mid-count reset at settled value 5
        #1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 reset mid-count", int'(count), 0);
        check("R6 no wrap from reset", wraps, 3);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 restart from zero", int'(count), 1);
        run_edges(1, 21, 3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule